// File: doc/BRIEF.md
# DMA Channel Ring Pointer Bank

This block keeps the ring pointers for a bank of DMA channels. Every channel owns two rings that live in host memory: a request ring that the host fills and the device drains, and a response ring that the device fills and the host drains. The block itself stores only the head and tail index of each ring and a base address for the channel's memory region. The host reaches these through a memory-mapped window of 4 KB per channel. The device side advances the pointers with one-cycle strobes, and it asks the block where the next request element sits and where the next response element must be written.

Each channel's memory region holds both rings back to back. The request ring starts at the region base and the response ring follows it, closing the region. An element's address is its ring's base plus the index times the element size. The block raises a one-cycle message interrupt per channel when a stored response turns an empty response ring non-empty. A completion can also force an interrupt. A response that would overfill the ring is refused and reported on a per-channel overflow pulse.

Top module: `dma_chan_ptr_bank`

## Requirements
- R1: Channel c occupies byte addresses c*4096 to c*4096+4095 of `host_addr`. Within a window, offset 0x0 reads the request head, 0x4 the request tail, 0x8 the response head, 0xC the response tail and 0x10 the region base. Index values are zero-extended to 32 bits. `host_rdata` shows the register addressed in the previous cycle.
- R2: A host write to offset 0x4 or 0x8 stores the low log2(RING_DEPTH) bits of `host_wdata`, so the index wraps modulo the depth. A host write to 0x10 stores all 32 bits.
- R3: Host writes to offset 0x0 (request head) and 0xC (response tail) change nothing.
- R4: Every other offset in a window reads as zero, and writes to it change nothing.
- R5: Reset is synchronous and active high. It clears every pointer and base, along with `msi`, `rsp_ovf`, `host_rdata` and the query outputs.
- R6: `dev_consume` advances the request head of `dev_consume_ch` by one, modulo the depth, when that request ring is non-empty (head differs from tail). On an empty ring it is ignored.
- R7: `dev_produce` advances the response tail of `dev_produce_ch` by one, modulo the depth. If the ring is full, meaning tail+1 equals head modulo the depth, the tail is left unchanged and that channel's `rsp_ovf` bit pulses for one cycle, in the cycle after the strobe.
- R8: A response accepted into an empty ring (head equal to tail) pulses that channel's `msi` bit for one cycle, in the cycle after the strobe.
- R9: An accepted response with `dev_force` high also pulses `msi`, whatever the ring's fill state. An accepted unforced response into a non-empty ring gives no pulse, and a refused response gives no `msi`.
- R10: One cycle after `dev_query_ch` is presented, `req_fetch_addr` = base + request head * REQ_BYTES and `rsp_store_addr` = base + RING_DEPTH*REQ_BYTES + response tail * RSP_BYTES. Both are taken modulo 2^32.
- R11: One cycle after `dev_query_ch` is presented, `req_occ` and `rsp_occ` give tail minus head modulo the depth for that channel's request and response rings.
- R12: When a host write and a device advance hit the same channel in the same cycle, both take effect. The device advance, its interrupt and its overflow decision are judged on the pointer values held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | log2(NUM_CH)+12 | Host byte address into the register space |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data for the previous address |
| dev_consume | input | 1 | Device consumed one request element |
| dev_consume_ch | input | log2(NUM_CH) | Channel of the consume strobe |
| dev_produce | input | 1 | Device completed a request and stores a response |
| dev_produce_ch | input | log2(NUM_CH) | Channel of the produce strobe |
| dev_force | input | 1 | Force an interrupt for this completion |
| dev_query_ch | input | log2(NUM_CH) | Channel for the address and occupancy lookup |
| req_fetch_addr | output | 32 | Address of the next request element to fetch |
| rsp_store_addr | output | 32 | Address of the next response slot |
| req_occ | output | log2(RING_DEPTH) | Request ring occupancy |
| rsp_occ | output | log2(RING_DEPTH) | Response ring occupancy |
| msi | output | NUM_CH | One-cycle interrupt pulse per channel |
| rsp_ovf | output | NUM_CH | One-cycle overflow pulse per channel |

## Verification
Two things can meet on one channel in a single cycle. The host can write the response head to drain the ring while the device stores a response, and the host can write the request tail while the device consumes. A directed case fills a response ring to the full mark, then drains it with a host head write in the very cycle of another produce. The expected result is an overflow pulse with the tail unmoved, since fullness is judged on the old head, and the new head still lands. A long random phase aims host writes and device strobes at the same channels, so these collisions recur often. A behavioural model compares every output on every clock.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  localparam int WIN_LOG2 = 12;

  typedef enum logic [2:0] {
    SEL_REQ_HEAD,
    SEL_REQ_TAIL,
    SEL_RSP_HEAD,
    SEL_RSP_TAIL,
    SEL_BASE,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e offset_to_sel(input logic [WIN_LOG2-1:0] ofs);
    case (ofs)
      12'h000: offset_to_sel = SEL_REQ_HEAD;
      12'h004: offset_to_sel = SEL_REQ_TAIL;
      12'h008: offset_to_sel = SEL_RSP_HEAD;
      12'h00C: offset_to_sel = SEL_RSP_TAIL;
      12'h010: offset_to_sel = SEL_BASE;
      default: offset_to_sel = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dcp_addr_decode.sv
module dcp_addr_decode
  import dcp_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + WIN_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   ch,
  output reg_sel_e          sel
);

  assign ch  = addr[ADDR_W-1:WIN_LOG2];
  assign sel = offset_to_sel(addr[WIN_LOG2-1:0]);

endmodule

// File: rtl/dcp_channel.sv
module dcp_channel
  import dcp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             consume,
  input  logic             produce,
  input  logic             force_irq,
  output logic [IDX_W-1:0] req_head,
  output logic [IDX_W-1:0] req_tail,
  output logic [IDX_W-1:0] rsp_head,
  output logic [IDX_W-1:0] rsp_tail,
  output logic [31:0]      base,
  output logic             irq,
  output logic             ovf
);

  logic             req_empty;
  logic             rsp_empty;
  logic             rsp_full;
  logic [IDX_W-1:0] rsp_tail_nxt;

  assign req_empty    = (req_head == req_tail);
  assign rsp_empty    = (rsp_head == rsp_tail);
  assign rsp_tail_nxt = rsp_tail + 1'b1;
  assign rsp_full     = (rsp_tail_nxt == rsp_head);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_head <= '0;
      req_tail <= '0;
      rsp_head <= '0;
      rsp_tail <= '0;
      base     <= '0;
      irq      <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      irq <= 1'b0;
      ovf <= 1'b0;
      if (consume && !req_empty) begin
        req_head <= req_head + 1'b1;
      end
      if (produce) begin
        if (rsp_full) begin
          ovf <= 1'b1;
        end else begin
          rsp_tail <= rsp_tail_nxt;
          irq      <= rsp_empty | force_irq;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_REQ_TAIL: req_tail <= wr_data[IDX_W-1:0];
          SEL_RSP_HEAD: rsp_head <= wr_data[IDX_W-1:0];
          SEL_BASE:     base     <= wr_data;
          default:      ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dcp_addr_calc.sv
module dcp_addr_calc #(
  parameter int RING_DEPTH = 64,
  parameter int REQ_BYTES  = 64,
  parameter int RSP_BYTES  = 4,
  localparam int IDX_W = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      base,
  input  logic [IDX_W-1:0] req_head,
  input  logic [IDX_W-1:0] req_tail,
  input  logic [IDX_W-1:0] rsp_head,
  input  logic [IDX_W-1:0] rsp_tail,
  output logic [31:0]      req_addr,
  output logic [31:0]      rsp_addr,
  output logic [IDX_W-1:0] req_occ,
  output logic [IDX_W-1:0] rsp_occ
);

  localparam logic [31:0] RSP_RING_OFS = 32'(RING_DEPTH * REQ_BYTES);
  localparam logic [31:0] REQ_SZ = 32'(REQ_BYTES);
  localparam logic [31:0] RSP_SZ = 32'(RSP_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_addr <= '0;
      rsp_addr <= '0;
      req_occ  <= '0;
      rsp_occ  <= '0;
    end else begin
      req_addr <= base + 32'(req_head) * REQ_SZ;
      rsp_addr <= base + RSP_RING_OFS + 32'(rsp_tail) * RSP_SZ;
      req_occ  <= req_tail - req_head;
      rsp_occ  <= rsp_tail - rsp_head;
    end
  end

endmodule

// File: rtl/dma_chan_ptr_bank.sv
module dma_chan_ptr_bank
  import dcp_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int RING_DEPTH = 64,
  parameter int REQ_BYTES  = 64,
  parameter int RSP_BYTES  = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(RING_DEPTH),
  localparam int ADDR_W = CH_W + WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              dev_consume,
  input  logic [CH_W-1:0]   dev_consume_ch,
  input  logic              dev_produce,
  input  logic [CH_W-1:0]   dev_produce_ch,
  input  logic              dev_force,
  input  logic [CH_W-1:0]   dev_query_ch,
  output logic [31:0]       req_fetch_addr,
  output logic [31:0]       rsp_store_addr,
  output logic [IDX_W-1:0]  req_occ,
  output logic [IDX_W-1:0]  rsp_occ,
  output logic [NUM_CH-1:0] msi,
  output logic [NUM_CH-1:0] rsp_ovf
);

  logic [CH_W-1:0] host_ch;
  reg_sel_e        host_sel;

  logic [NUM_CH-1:0][IDX_W-1:0] req_head_a;
  logic [NUM_CH-1:0][IDX_W-1:0] req_tail_a;
  logic [NUM_CH-1:0][IDX_W-1:0] rsp_head_a;
  logic [NUM_CH-1:0][IDX_W-1:0] rsp_tail_a;
  logic [NUM_CH-1:0][31:0]      base_a;

  dcp_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr (host_addr),
    .ch   (host_ch),
    .sel  (host_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcp_channel #(.IDX_W(IDX_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (host_wr && (host_ch == CH_W'(c))),
      .wr_sel    (host_sel),
      .wr_data   (host_wdata),
      .consume   (dev_consume && (dev_consume_ch == CH_W'(c))),
      .produce   (dev_produce && (dev_produce_ch == CH_W'(c))),
      .force_irq (dev_force),
      .req_head  (req_head_a[c]),
      .req_tail  (req_tail_a[c]),
      .rsp_head  (rsp_head_a[c]),
      .rsp_tail  (rsp_tail_a[c]),
      .base      (base_a[c]),
      .irq       (msi[c]),
      .ovf       (rsp_ovf[c])
    );
  end

  logic [31:0] rd_mux;

  always_comb begin
    case (host_sel)
      SEL_REQ_HEAD: rd_mux = 32'(req_head_a[host_ch]);
      SEL_REQ_TAIL: rd_mux = 32'(req_tail_a[host_ch]);
      SEL_RSP_HEAD: rd_mux = 32'(rsp_head_a[host_ch]);
      SEL_RSP_TAIL: rd_mux = 32'(rsp_tail_a[host_ch]);
      SEL_BASE:     rd_mux = base_a[host_ch];
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_mux;
  end

  dcp_addr_calc #(
    .RING_DEPTH (RING_DEPTH),
    .REQ_BYTES  (REQ_BYTES),
    .RSP_BYTES  (RSP_BYTES)
  ) u_calc (
    .clk      (clk),
    .rst      (rst),
    .base     (base_a[dev_query_ch]),
    .req_head (req_head_a[dev_query_ch]),
    .req_tail (req_tail_a[dev_query_ch]),
    .rsp_head (rsp_head_a[dev_query_ch]),
    .rsp_tail (rsp_tail_a[dev_query_ch]),
    .req_addr (req_fetch_addr),
    .rsp_addr (rsp_store_addr),
    .req_occ  (req_occ),
    .rsp_occ  (rsp_occ)
  );

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 6
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         dev_produce,
  input logic [NUM_CH-1:0]            msi,
  input logic [NUM_CH-1:0]            rsp_ovf,
  input logic [NUM_CH-1:0][IDX_W-1:0] req_head_a,
  input logic [NUM_CH-1:0][IDX_W-1:0] rsp_tail_a
);

  // R8: an interrupt only follows a produce strobe
  a_r8_msi_after_produce: assert property (@(posedge clk) disable iff (rst)
    (|msi) |-> $past(dev_produce));

  // R7: an overflow only follows a produce strobe
  a_r7_ovf_after_produce: assert property (@(posedge clk) disable iff (rst)
    (|rsp_ovf) |-> $past(dev_produce));

  // R9: a refused response never raises an interrupt on its channel
  a_r9_ovf_no_msi: assert property (@(posedge clk) disable iff (rst)
    (msi & rsp_ovf) == '0);

  // R8: one produce strobe per cycle gives at most one pulse
  a_r8_single_msi: assert property (@(posedge clk) disable iff (rst)
    $onehot0(msi));

  a_r7_single_ovf: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_ovf));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7: a refused response leaves the tail where it was
    a_r7_tail_held: assert property (@(posedge clk) disable iff (rst)
      rsp_ovf[c] |-> (rsp_tail_a[c] == $past(rsp_tail_a[c])));

    // R6: the request head only ever moves forward by one
    a_r6_head_step: assert property (@(posedge clk) disable iff (rst)
      (req_head_a[c] != $past(req_head_a[c])) |->
        (req_head_a[c] == IDX_W'($past(req_head_a[c]) + 1'b1)));

    // R7: the response tail only ever moves forward by one
    a_r7_tail_step: assert property (@(posedge clk) disable iff (rst)
      (rsp_tail_a[c] != $past(rsp_tail_a[c])) |->
        (rsp_tail_a[c] == IDX_W'($past(rsp_tail_a[c]) + 1'b1)));
  end

endmodule

bind dma_chan_ptr_bank dcp_checker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dev_produce (dev_produce),
  .msi         (msi),
  .rsp_ovf     (rsp_ovf),
  .req_head_a  (req_head_a),
  .rsp_tail_a  (rsp_tail_a)
);

// File: tb/dma_chan_ptr_bank_tb.sv
module dma_chan_ptr_bank_tb;

  localparam int NCH   = 16;
  localparam int DEP   = 8;
  localparam int RQB   = 64;
  localparam int RSB   = 4;
  localparam int CW    = 4;
  localparam int IW    = 3;
  localparam int AW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic          host_wr = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          dev_consume = 1'b0;
  logic [CW-1:0] dev_consume_ch = '0;
  logic          dev_produce = 1'b0;
  logic [CW-1:0] dev_produce_ch = '0;
  logic          dev_force = 1'b0;
  logic [CW-1:0] dev_query_ch = '0;
  logic [31:0]   req_fetch_addr, rsp_store_addr;
  logic [IW-1:0] req_occ, rsp_occ;
  logic [NCH-1:0] msi, rsp_ovf;

  always #2 clk = ~clk;

  dma_chan_ptr_bank #(.NUM_CH(NCH), .RING_DEPTH(DEP), .REQ_BYTES(RQB),
                      .RSP_BYTES(RSB)) u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_consume(dev_consume), .dev_consume_ch(dev_consume_ch),
    .dev_produce(dev_produce), .dev_produce_ch(dev_produce_ch),
    .dev_force(dev_force), .dev_query_ch(dev_query_ch),
    .req_fetch_addr(req_fetch_addr), .rsp_store_addr(rsp_store_addr),
    .req_occ(req_occ), .rsp_occ(rsp_occ), .msi(msi), .rsp_ovf(rsp_ovf)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_rqh[NCH], m_rqt[NCH], m_rsh[NCH], m_rst[NCH];
  bit [31:0]   m_base[NCH];
  bit [31:0]   e_rdata, e_rqa, e_rsa;
  int          e_rqo, e_rso;
  bit [NCH-1:0] e_msi, e_ovf;
  string       rd_tag;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_rqh[c] = 0; m_rqt[c] = 0; m_rsh[c] = 0; m_rst[c] = 0; m_base[c] = 0;
      end
      e_rdata = 0; e_rqa = 0; e_rsa = 0; e_rqo = 0; e_rso = 0;
      e_msi = '0; e_ovf = '0; rd_tag = "R5";
    end else begin
      int hc, ho, qc;
      hc = int'(host_addr[15:12]);
      ho = int'(host_addr[11:0]);
      case (ho)
        0:  begin e_rdata = m_rqh[hc];  rd_tag = "R1"; end
        4:  begin e_rdata = m_rqt[hc];  rd_tag = "R1"; end
        8:  begin e_rdata = m_rsh[hc];  rd_tag = "R1"; end
        12: begin e_rdata = m_rst[hc];  rd_tag = "R1"; end
        16: begin e_rdata = m_base[hc]; rd_tag = "R2"; end
        default: begin e_rdata = 0; rd_tag = "R4"; end
      endcase
      qc = int'(dev_query_ch);
      e_rqa = m_base[qc] + 32'(m_rqh[qc] * RQB);
      e_rsa = m_base[qc] + 32'(DEP * RQB) + 32'(m_rst[qc] * RSB);
      e_rqo = (m_rqt[qc] - m_rqh[qc] + DEP) % DEP;
      e_rso = (m_rst[qc] - m_rsh[qc] + DEP) % DEP;
      e_msi = '0; e_ovf = '0;
      // device events judged on pre-edge state (R12)
      if (dev_consume) begin
        int c; c = int'(dev_consume_ch);
        if (m_rqh[c] != m_rqt[c]) m_rqh[c] = (m_rqh[c] + 1) % DEP;
      end
      if (dev_produce) begin
        int c; c = int'(dev_produce_ch);
        if (((m_rst[c] + 1) % DEP) == m_rsh[c]) e_ovf[c] = 1'b1;
        else begin
          if (m_rst[c] == m_rsh[c] || dev_force) e_msi[c] = 1'b1;
          m_rst[c] = (m_rst[c] + 1) % DEP;
        end
      end
      if (host_wr) begin
        case (ho)
          4:  m_rqt[hc] = int'(host_wdata) & (DEP - 1);
          8:  m_rsh[hc] = int'(host_wdata) & (DEP - 1);
          16: m_base[hc] = host_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    #1;
    check(host_rdata == e_rdata, rd_tag, "host_rdata", host_rdata, e_rdata);
    check(req_fetch_addr == e_rqa, "R10", "req_fetch_addr", req_fetch_addr, e_rqa);
    check(rsp_store_addr == e_rsa, "R10", "rsp_store_addr", rsp_store_addr, e_rsa);
    check(int'(req_occ) == e_rqo, "R11", "req_occ", req_occ, e_rqo);
    check(int'(rsp_occ) == e_rso, "R11", "rsp_occ", rsp_occ, e_rso);
    check(msi == e_msi, "R8", "msi", msi, e_msi);
    check(rsp_ovf == e_ovf, "R7", "rsp_ovf", rsp_ovf, e_ovf);
  end

  // stimulus helpers, each entered at a falling edge
  task automatic hw(input int ch, input int ofs, input bit [31:0] d);
    host_addr = AW'(ch * 4096 + ofs); host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hr(input int ch, input int ofs, output bit [31:0] d);
    host_addr = AW'(ch * 4096 + ofs);
    @(posedge clk); #1; d = host_rdata;
    @(negedge clk);
  endtask

  task automatic prod(input int ch, input bit frc, output bit [NCH-1:0] m,
                      output bit [NCH-1:0] o);
    dev_produce = 1'b1; dev_produce_ch = CW'(ch); dev_force = frc;
    @(posedge clk); #1; m = msi; o = rsp_ovf;
    @(negedge clk); dev_produce = 1'b0; dev_force = 1'b0;
  endtask

  task automatic cons(input int ch);
    dev_consume = 1'b1; dev_consume_ch = CW'(ch);
    @(negedge clk); dev_consume = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [31:0] v;
    bit [NCH-1:0] m, o;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R5: reset state
    check(msi == '0 && rsp_ovf == '0, "R5", "irq/ovf after reset", {msi, rsp_ovf}, 0);
    hr(5, 16, v); check(v == 0, "R5", "base after reset", v, 0);
    hr(5, 12, v); check(v == 0, "R5", "rsp tail after reset", v, 0);
    // R2: writable registers with wrap
    hw(2, 4, 5);  hr(2, 4, v); check(v == 5, "R2", "req tail", v, 5);
    hw(2, 4, 13); hr(2, 4, v); check(v == 5, "R2", "req tail wrap", v, 5);
    hw(2, 16, 32'h1000_0000); hr(2, 16, v);
    check(v == 32'h1000_0000, "R2", "base", v, 32'h1000_0000);
    // R3: device-owned pointers ignore host writes
    hw(2, 0, 6); hr(2, 0, v); check(v == 0, "R3", "req head", v, 0);
    hw(2, 12, 3); hr(2, 12, v); check(v == 0, "R3", "rsp tail", v, 0);
    // R4: unmapped offset
    hw(2, 20, 32'hdead_beef); hr(2, 20, v); check(v == 0, "R4", "unmapped", v, 0);
    hr(2, 4, v); check(v == 5, "R4", "neighbour intact", v, 5);
    // R6: consume on non-empty and empty rings
    cons(2); hr(2, 0, v); check(v == 1, "R6", "head advance", v, 1);
    cons(4); hr(4, 0, v); check(v == 0, "R6", "empty consume ignored", v, 0);
    // R8 / R9: interrupt rule
    prod(7, 0, m, o); check(m[7] == 1'b1, "R8", "empty->nonempty msi", m, 16'h0080);
    prod(7, 0, m, o); check(m == '0, "R9", "no msi when nonempty", m, 0);
    prod(7, 1, m, o); check(m[7] == 1'b1, "R9", "forced msi", m, 16'h0080);
    // R7: fill to full and overflow
    for (int i = 0; i < DEP - 1; i++) prod(9, 0, m, o);
    prod(9, 1, m, o);
    check(o[9] == 1'b1, "R7", "overflow pulse", o, 16'h0200);
    check(m == '0, "R9", "no msi on refused", m, 0);
    hr(9, 12, v); check(v == 7, "R7", "tail held", v, 7);
    // R10 / R11: lookup
    hw(9, 16, 32'h2000);
    dev_query_ch = 4'd9; @(posedge clk); #1;
    check(rsp_store_addr == 32'h221C, "R10", "rsp addr", rsp_store_addr, 32'h221C);
    check(req_fetch_addr == 32'h2000, "R10", "req addr", req_fetch_addr, 32'h2000);
    check(rsp_occ == 3'd7, "R11", "rsp occ", rsp_occ, 7);
    @(negedge clk); dev_query_ch = 4'd2; @(posedge clk); #1;
    check(req_occ == 3'd4, "R11", "req occ", req_occ, 4);
    @(negedge clk);
    // R12: drain write and produce in the same cycle on a full ring
    host_addr = AW'(9 * 4096 + 8); host_wr = 1'b1; host_wdata = 3;
    prod(9, 0, m, o);
    host_wr = 1'b0;
    check(o[9] == 1'b1, "R12", "full judged on old head", o, 16'h0200);
    hr(9, 8, v); check(v == 3, "R12", "head write landed", v, 3);
    hr(9, 12, v); check(v == 7, "R12", "tail held", v, 7);
    prod(9, 0, m, o); check(m == '0 && o == '0, "R12", "accepted after drain", {m, o}, 0);
    // random mix, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      int ofs_sel;
      ofs_sel = $urandom_range(0, 6);
      host_addr = AW'($urandom_range(0, NCH - 1) * 4096 +
                      (ofs_sel < 5 ? ofs_sel * 4 : (ofs_sel == 5 ? 20 : 2048)));
      host_wr = 1'($urandom_range(0, 1));
      host_wdata = $urandom;
      dev_consume = 1'($urandom_range(0, 1));
      dev_consume_ch = CW'($urandom_range(0, 3));
      dev_produce = 1'($urandom_range(0, 1));
      dev_produce_ch = CW'($urandom_range(0, 3));
      dev_force = ($urandom_range(0, 4) == 0);
      dev_query_ch = CW'($urandom_range(0, NCH - 1));
      @(negedge clk);
    end
    host_wr = 1'b0; dev_consume = 1'b0; dev_produce = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule